// File: doc/BRIEF.md
# Rotating Offset Register Load and Readback Unit

This block keeps the two threshold offsets that a FIFO's programmable flag logic compares its fill level against: one offset for the almost-empty flag and one for the almost-full flag. Each offset is stored as two byte-wide registers. One register holds bits 7:0. The other, the upper register, holds only the bits above bit 7 that the FIFO's address width needs. The complete offsets are presented continuously on two output buses, ready for the flag comparators.

Software or a controlling state machine reaches all four registers through one 8-bit write port and one 8-bit read port. No register address is supplied. A single 2-bit selection pointer decides which register an access touches, and the pointer steps forward by one after every accepted access. A load session may update only some of the registers. Because the pointer is not cleared between sessions, the next session continues at the register after the last one accessed.

Reset loads both offsets with the value 7 and returns the pointer to the first register. The FIFO storage and the flag comparison are outside this block.

Top module: `offs_load_unit`

## Requirements
- R1: After reset, both offset outputs equal 7, the read data output is 0, and the pointer selects the empty-offset low register. The low registers hold 07h and the upper registers hold 0.
- R2: Accepted accesses visit the registers in the following fixed cycle. Pointer code 0 is the empty-offset low byte, 1 is the empty-offset upper part, 2 is the full-offset low byte and 3 is the full-offset upper part. The fifth access wraps back to code 0.
- R3: A write is accepted on a rising clock edge only when `load_n` is 0 and `wr_en_n` is 0. Otherwise the offsets and the pointer are unchanged.
- R4: The pointer keeps its position while `load_n` is high. A later load session resumes at the register that follows the last one accessed.
- R5: A read is accepted on a rising clock edge when `load_n`, `rd_en1_n` and `rd_en2_n` are all 0. `dout` then shows the selected register from that edge onward, and it holds its value until the next accepted read.
- R6: If either read enable is 1, or `load_n` is 1, no read takes place. In that case `dout` and the pointer are unchanged.
- R7: If a write and a read are requested in the same cycle, only the write is performed. `dout` holds its value and the pointer advances by exactly one.
- R8: A low register stores `din[7:0]`. An upper register stores only `din[ADDR_W-9:0]`, and when it is read back, bits of `dout` above that width are 0.
- R9: `ae_offset` and `af_offset` are the concatenation {upper register, low register} of their offset. They are updated on the edge that writes either part.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_n | input | 1 | Offset access mode, active low |
| wr_en_n | input | 1 | Write strobe, active low |
| rd_en1_n | input | 1 | First read enable, active low |
| rd_en2_n | input | 1 | Second read enable, active low |
| din | input | 8 | Write data |
| dout | output | 8 | Registered readback data |
| ae_offset | output | ADDR_W | Almost-empty offset to the flag logic |
| af_offset | output | ADDR_W | Almost-full offset to the flag logic |

## Verification
Assertions check several properties on every cycle. The pointer steps by exactly one after an accepted access and stays put otherwise. The offsets stay stable whenever no write is accepted. The readback register holds without an accepted read, including when a write and a read collide. Readback of an upper register never carries bits beyond the address width. Only the directed scenarios can show that data lands in the right register in the rotating order, that a fifth access wraps, and that a split load session resumes at the correct register. They also show that the read port walks the same order, and that the reset defaults are the values the flag logic actually sees.

// File: rtl/offs_pkg.sv
package offs_pkg;

    // Pointer codes; the order is the access sequence.
    typedef enum logic [1:0] {
        SEL_AE_LO = 2'd0,
        SEL_AE_HI = 2'd1,
        SEL_AF_LO = 2'd2,
        SEL_AF_HI = 2'd3
    } offs_sel_e;

    localparam int unsigned LO_W      = 8;
    localparam int unsigned N_OFFSETS = 2;
    localparam logic [LO_W-1:0] LO_DEFAULT = 8'h07;

endpackage

// File: rtl/offs_seq.sv
module offs_seq
    import offs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      load_n,
    input  logic      wr_en_n,
    input  logic      rd_en1_n,
    input  logic      rd_en2_n,
    output logic      wr_acc,
    output logic      rd_acc,
    output offs_sel_e sel
);

    typedef struct packed {
        offs_sel_e sel;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       acc;

    always_comb begin
        st_d   = st_q;
        wr_acc = !load_n && !wr_en_n;
        // Write wins a collision; the read is dropped.
        rd_acc = !load_n && !rd_en1_n && !rd_en2_n && !wr_acc;
        acc    = wr_acc || rd_acc;
        if (acc) begin
            st_d.sel = offs_sel_e'(2'(st_q.sel + 2'd1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: SEL_AE_LO};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel = st_q.sel;

    // R2, R7: one step per accepted access
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_n && (!wr_en_n || (!rd_en1_n && !rd_en2_n)))
        |=> (sel == offs_sel_e'(2'($past(sel) + 2'd1))));

    // R4, R6: no access, no movement
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (load_n || (wr_en_n && (rd_en1_n || rd_en2_n)))
        |=> $stable(sel));

endmodule

// File: rtl/offs_regfile.sv
module offs_regfile
    import offs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 wr_acc,
    input  offs_sel_e                            sel,
    input  logic [LO_W-1:0]                      din,
    output logic [N_OFFSETS-1:0][ADDR_W-1:0]     offs
);

    localparam int unsigned HI_W = ADDR_W - LO_W;

    typedef struct packed {
        logic [N_OFFSETS-1:0][LO_W-1:0] lo;
        logic [N_OFFSETS-1:0][HI_W-1:0] hi;
    } rf_state_t;

    rf_state_t  rf_d, rf_q;
    logic [1:0] sel_bits;

    always_comb begin
        rf_d     = rf_q;
        sel_bits = sel;
        if (wr_acc) begin
            // bit 1 picks the offset, bit 0 picks the part
            if (sel_bits[0]) begin
                rf_d.hi[sel_bits[1]] = din[HI_W-1:0];
            end else begin
                rf_d.lo[sel_bits[1]] = din;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rf_q.lo <= {N_OFFSETS{LO_DEFAULT}};
            rf_q.hi <= '0;
        end else begin
            rf_q <= rf_d;
        end
    end

    for (genvar g = 0; g < N_OFFSETS; g++) begin : g_offs
        assign offs[g] = {rf_q.hi[g], rf_q.lo[g]};
    end

    // R3: offsets move only on an accepted write
    a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_acc |=> $stable(offs));

endmodule

// File: rtl/offs_rdback.sv
module offs_rdback
    import offs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             rd_acc,
    input  logic                             wr_acc,
    input  offs_sel_e                        sel,
    input  logic [N_OFFSETS-1:0][ADDR_W-1:0] offs,
    output logic [LO_W-1:0]                  dout
);

    localparam int unsigned HI_W = ADDR_W - LO_W;

    typedef struct packed {
        logic [LO_W-1:0] data;
    } rb_state_t;

    rb_state_t       rb_d, rb_q;
    logic [1:0]      sel_bits;
    logic [ADDR_W-1:0] picked;

    always_comb begin
        rb_d     = rb_q;
        sel_bits = sel;
        picked   = offs[sel_bits[1]];
        if (rd_acc) begin
            if (sel_bits[0]) begin
                rb_d.data = LO_W'(picked[ADDR_W-1:LO_W]);
            end else begin
                rb_d.data = picked[LO_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rb_q <= '{data: '0};
        end else begin
            rb_q <= rb_d;
        end
    end

    assign dout = rb_q.data;

    // R6: readback holds without an accepted read
    a_r6_dout_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> $stable(dout));

    // R7: a collision leaves the readback alone
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr_acc |=> $stable(dout));

    // R8: upper-part readback carries no bits past the address width
    a_r8_hi_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && (sel == SEL_AE_HI || sel == SEL_AF_HI))
        |=> ((dout >> HI_W) == '0));

endmodule

// File: rtl/offs_load_unit.sv
module offs_load_unit
    import offs_pkg::*;
#(
    parameter int unsigned ADDR_W = 12   // 9..16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_n,
    input  logic              wr_en_n,
    input  logic              rd_en1_n,
    input  logic              rd_en2_n,
    input  logic [LO_W-1:0]   din,
    output logic [LO_W-1:0]   dout,
    output logic [ADDR_W-1:0] ae_offset,
    output logic [ADDR_W-1:0] af_offset
);

    logic                             wr_acc;
    logic                             rd_acc;
    offs_sel_e                        sel;
    logic [N_OFFSETS-1:0][ADDR_W-1:0] offs;

    offs_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_n   (load_n),
        .wr_en_n  (wr_en_n),
        .rd_en1_n (rd_en1_n),
        .rd_en2_n (rd_en2_n),
        .wr_acc   (wr_acc),
        .rd_acc   (rd_acc),
        .sel      (sel)
    );

    offs_regfile #(.ADDR_W(ADDR_W)) u_regfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_acc (wr_acc),
        .sel    (sel),
        .din    (din),
        .offs   (offs)
    );

    offs_rdback #(.ADDR_W(ADDR_W)) u_rdback (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_acc (rd_acc),
        .wr_acc (wr_acc),
        .sel    (sel),
        .offs   (offs),
        .dout   (dout)
    );

    assign ae_offset = offs[0];
    assign af_offset = offs[1];

endmodule

// File: tb/offs_load_unit_bench.sv
module offs_load_unit_bench;

    localparam int unsigned ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load_n = 1'b1;
    logic              wr_en_n = 1'b1;
    logic              rd_en1_n = 1'b1;
    logic              rd_en2_n = 1'b1;
    logic [7:0]        din = '0;
    logic [7:0]        dout;
    logic [ADDR_W-1:0] ae_offset;
    logic [ADDR_W-1:0] af_offset;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    offs_load_unit #(.ADDR_W(ADDR_W)) u_offs_load_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .wr_en_n   (wr_en_n),
        .rd_en1_n  (rd_en1_n),
        .rd_en2_n  (rd_en2_n),
        .din       (din),
        .dout      (dout),
        .ae_offset (ae_offset),
        .af_offset (af_offset)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] d);
        load_n = 1'b0; wr_en_n = 1'b0; din = d;
        step();
        wr_en_n = 1'b1;
    endtask

    task automatic rd();
        load_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0;
        step();
        rd_en1_n = 1'b1; rd_en2_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 ae_offset after reset", 32'(ae_offset), 32'h007);
        check("R1 af_offset after reset", 32'(af_offset), 32'h007);
        check("R1 dout after reset", 32'(dout), 32'h00);
    endtask

    task automatic t_write_seq();
        wr(8'h15); wr(8'hA3); wr(8'hC2); wr(8'hF5);
        load_n = 1'b1;
        step();
        check("R2 R8 R9 ae_offset after four writes", 32'(ae_offset), 32'h315);
        check("R2 R8 R9 af_offset after four writes", 32'(af_offset), 32'h5C2);
    endtask

    task automatic t_read_seq();
        rd(); check("R5 read 1 empty low", 32'(dout), 32'h15);
        rd(); check("R5 R8 read 2 empty upper", 32'(dout), 32'h03);
        rd(); check("R5 read 3 full low", 32'(dout), 32'hC2);
        rd(); check("R5 R8 read 4 full upper", 32'(dout), 32'h05);
        rd(); check("R2 R5 read 5 wraps", 32'(dout), 32'h15);
        load_n = 1'b1;
        step();
        check("R5 dout holds with no read", 32'(dout), 32'h15);
    endtask

    task automatic t_ignored();
        load_n = 1'b1; wr_en_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0; din = 8'hAA;
        step();
        wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        check("R3 ae_offset with load released", 32'(ae_offset), 32'h315);
        check("R3 af_offset with load released", 32'(af_offset), 32'h5C2);
        check("R6 dout with load released", 32'(dout), 32'h15);
        load_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b1;
        step();
        rd_en1_n = 1'b1;
        check("R6 dout with one read enable", 32'(dout), 32'h15);
        load_n = 1'b0; rd_en1_n = 1'b1; rd_en2_n = 1'b0;
        step();
        rd_en2_n = 1'b1;
        check("R6 dout with other read enable", 32'(dout), 32'h15);
        rd();
        check("R3 R6 pointer unmoved, empty upper next", 32'(dout), 32'h03);
        load_n = 1'b1;
        step();
    endtask

    task automatic t_partial();
        wr(8'h40);
        load_n = 1'b1;
        step(); step();
        wr(8'h01);
        load_n = 1'b1;
        step();
        check("R4 af_offset after split session", 32'(af_offset), 32'h140);
        check("R4 ae_offset untouched by split session", 32'(ae_offset), 32'h315);
    endtask

    task automatic t_collision();
        load_n = 1'b0; wr_en_n = 1'b0; rd_en1_n = 1'b0; rd_en2_n = 1'b0; din = 8'h22;
        step();
        wr_en_n = 1'b1; rd_en1_n = 1'b1; rd_en2_n = 1'b1;
        check("R7 dout holds on collision", 32'(dout), 32'h03);
        check("R7 write performed on collision", 32'(ae_offset), 32'h322);
        rd();
        check("R7 pointer advanced once", 32'(dout), 32'h03);
        load_n = 1'b1;
        step();
    endtask

    task automatic t_wrap_write();
        wr(8'h11); wr(8'h02); wr(8'h33); wr(8'h04); wr(8'h55);
        load_n = 1'b1;
        step();
        check("R2 fifth write wraps to full low", 32'(af_offset), 32'h255);
        check("R2 ae_offset after wrap writes", 32'(ae_offset), 32'h433);
    endtask

    task automatic t_reset_mid();
        rst_n = 1'b0;
        step();
        check("R1 ae_offset mid reset", 32'(ae_offset), 32'h007);
        check("R1 af_offset mid reset", 32'(af_offset), 32'h007);
        check("R1 dout mid reset", 32'(dout), 32'h00);
        rst_n = 1'b1;
        step();
        rd();
        check("R1 pointer at empty low after reset", 32'(dout), 32'h07);
        rd();
        check("R1 empty upper default zero", 32'(dout), 32'h00);
        load_n = 1'b1;
        step();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();
        t_reset();
        t_write_seq();
        t_read_seq();
        t_ignored();
        t_partial();
        t_collision();
        t_wrap_write();
        t_reset_mid();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1..R9 actual=timeout expected=complete");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule